// File: doc/BRIEF.md
# Dual-Hash Exact-Match Flow Lookup Engine

This block classifies packets by their 248-bit flow header. For every accepted request it forms two flow indices from two different CRC-32 polynomials. Each index selects a 16-entry slot in a single-port 512 x 64 table memory. The engine compares the header words stored in the first candidate slot against the request and moves to the second candidate slot only when that comparison fails. On a match it returns the slot's action word and updates the packet and byte counters that the slot keeps for the requesting port; on no match it flags the packet for dropping.

The table is filled and inspected by a host through a simple memory port, which is serviced only while the engine is idle. The engine handles one request at a time. It accepts a new request only after the counter read-modify-write cycles of the previous one have finished, so the counters in the table always reflect every hit that has been reported.

FSM states: `ST_IDLE` (host access or request acceptance), `ST_HASH` (register both indices), `ST_HDR_RD` / `ST_HDR_CMP` (read and compare one header word), `ST_ACT_RD` / `ST_ACT_CAP` (fetch the action), `ST_CNT_RD` / `ST_CNT_WR` (read-modify-write one counter), `ST_HIT` / `ST_MISS` (one-cycle result).

Transitions:
- ST_IDLE to ST_HASH on an accepted request.
- ST_HASH to ST_HDR_RD, then ST_HDR_RD to ST_HDR_CMP.
- From ST_HDR_CMP, a matching word that is not the last goes back to ST_HDR_RD for the next word. A matching last word goes to ST_ACT_RD. A mismatch in the first slot goes back to ST_HDR_RD at word 0 of the second slot. A mismatch in the second slot goes to ST_MISS.
- ST_ACT_RD to ST_ACT_CAP, then ST_ACT_CAP to ST_CNT_RD.
- ST_CNT_RD to ST_CNT_WR. ST_CNT_WR goes back to ST_CNT_RD after the packet counter and to ST_HIT after the byte counter.
- ST_HIT and ST_MISS both return to ST_IDLE.

Top module: `flow_match_engine`

## Requirements
- R1: Both flow indices are taken from the same 256-bit word P = {8'h00, header}. The CRC register starts at 32'hFFFFFFFF and has no final XOR. The bits of P are fed in the order P[0], P[1], ... P[255], which is the bit-reversed word taken most significant bit first. Each step is crc = {crc[30:0],0} XOR (poly if crc[31] XOR bit). Index 0 uses poly 32'h04C11DB7 and index 1 uses 32'h1EDC6F41, and each index is crc[4:0].
- R2: A slot for index i covers table addresses i*16 to i*16+15. Words 0 to 3 hold P from most significant 64 bits to least, and word 4 holds the action. For port p, word 5+2p holds the packet counter and word 6+2p holds the byte counter.
- R3: The slot of index 0 is compared first. When all four header words match, the result has hit=1, drop=0 and carries that slot's action word.
- R4: When the index-0 slot does not match, the index-1 slot is compared. A full match there gives a hit with that slot's action.
- R5: When neither slot matches, the result has drop=1, hit=0 and action 0, and no counter in the table changes.
- R6: On a hit, the packet counter of the requesting port in the matching slot increases by 1 and its byte counter increases by the request length. The counters of other ports and of other slots are unchanged.
- R7: A request is accepted when req_valid and req_ready are both high. req_ready then stays low until the result is given. Each accepted request produces exactly one result, as a one-cycle res_valid pulse, and res_hit and res_drop are low outside that pulse.
- R8: While idle, a cycle with tbl_en high accesses the table at tbl_addr. With tbl_we high it writes tbl_wdata; with tbl_we low, tbl_rdata shows the word in the following cycle. req_ready is low in every cycle in which tbl_en is high.
- R9: After reset, res_valid is low and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Engine can accept a request |
| req_hdr | input | 248 | Flow header |
| req_port | input | 2 | Ingress port of the packet |
| req_len | input | 16 | Packet length in bytes |
| res_valid | output | 1 | Result pulse |
| res_hit | output | 1 | Header found |
| res_drop | output | 1 | No matching flow, drop packet |
| res_action | output | 64 | Action word of the matched flow |
| tbl_en | input | 1 | Host table access |
| tbl_we | input | 1 | Host write (else read) |
| tbl_addr | input | 9 | Host table address |
| tbl_wdata | input | 64 | Host write data |
| tbl_rdata | output | 64 | Table read data, one cycle after the read |

## Verification
The bench places one flow only in its index-0 slot and a second flow only in its index-1 slot, chosen so that the two slots differ. A design that hashed the wrong bit order, the wrong initial value or the wrong polynomial would report a miss for one of these flows. A design that never fell back to the second slot would drop the second flow. A third header that is never written must drop with action 0. The bench then reads every port's counters back through the host port: an off-by-one counter offset or a byte increment applied to the wrong word shows up as a wrong value in a neighbouring port's counter, which should still be zero. The bench also checks that the engine stays busy right after acceptance and that a host access blocks acceptance, which catches a design that lets a second lookup overlap an unfinished counter update.

// File: rtl/flow_match_pkg.sv
`timescale 1ns/1ps
package flow_match_pkg;

    localparam logic [31:0] CRC_POLY_IDX0 = 32'h04C11DB7;
    localparam logic [31:0] CRC_POLY_IDX1 = 32'h1EDC6F41;
    localparam logic [31:0] CRC_SEED      = 32'hFFFFFFFF;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HASH,
        ST_HDR_RD,
        ST_HDR_CMP,
        ST_ACT_RD,
        ST_ACT_CAP,
        ST_CNT_RD,
        ST_CNT_WR,
        ST_HIT,
        ST_MISS
    } fm_state_e;

endpackage

// File: rtl/flow_table_mem.sv
`timescale 1ns/1ps
module flow_table_mem #(
    parameter int DEPTH = 512,
    parameter int WIDTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             en,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] store [DEPTH];

    // single port, registered read, read returns the old word on a write cycle
    always_ff @(posedge clk) begin
        if (en) begin
            rdata <= store[addr];
            if (we) begin
                store[addr] <= wdata;
            end
        end
    end

endmodule

// File: rtl/flow_crc_index.sv
`timescale 1ns/1ps
module flow_crc_index #(
    parameter int          HDR_W = 248,
    parameter int          PAD_W = 256,
    parameter int          IDX_W = 5,
    parameter logic [31:0] POLY  = 32'h04C11DB7,
    parameter logic [31:0] SEED  = 32'hFFFFFFFF
) (
    input  logic [HDR_W-1:0] hdr,
    output logic [IDX_W-1:0] idx
);

    logic [PAD_W-1:0] padded;
    logic [PAD_W-1:0] reversed;
    logic [31:0]      crc;

    assign padded = {{(PAD_W-HDR_W){1'b0}}, hdr};

    for (genvar b = 0; b < PAD_W; b++) begin : g_rev
        assign reversed[b] = padded[PAD_W-1-b];
    end

    // serial CRC unrolled, reversed word fed from its top bit down
    always_comb begin
        crc = SEED;
        for (int i = PAD_W - 1; i >= 0; i--) begin
            crc = {crc[30:0], 1'b0} ^ ({32{crc[31] ^ reversed[i]}} & POLY);
        end
    end

    assign idx = crc[IDX_W-1:0];

endmodule

// File: rtl/flow_match_engine.sv
`timescale 1ns/1ps
module flow_match_engine
    import flow_match_pkg::*;
#(
    parameter int HDR_W        = 248,
    parameter int WORD_W       = 64,
    parameter int DEPTH        = 512,
    parameter int SLOT_ENTRIES = 16,
    parameter int NUM_PORTS    = 4,
    parameter int LEN_W        = 16,
    localparam int ADDR_W      = $clog2(DEPTH),
    localparam int PORT_W      = $clog2(NUM_PORTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [HDR_W-1:0]  req_hdr,
    input  logic [PORT_W-1:0] req_port,
    input  logic [LEN_W-1:0]  req_len,
    output logic              res_valid,
    output logic              res_hit,
    output logic              res_drop,
    output logic [WORD_W-1:0] res_action,
    input  logic              tbl_en,
    input  logic              tbl_we,
    input  logic [ADDR_W-1:0] tbl_addr,
    input  logic [WORD_W-1:0] tbl_wdata,
    output logic [WORD_W-1:0] tbl_rdata
);

    localparam int SLOT_W    = $clog2(SLOT_ENTRIES);
    localparam int IDX_W     = ADDR_W - SLOT_W;
    localparam int PAD_W     = ((HDR_W + WORD_W - 1) / WORD_W) * WORD_W;
    localparam int HDR_WORDS = PAD_W / WORD_W;
    localparam int ACT_OFS   = HDR_WORDS;
    localparam int CNT_OFS   = HDR_WORDS + 1;

    fm_state_e state_q, state_d;

    logic [HDR_W-1:0]  hdr_q;
    logic [PORT_W-1:0] port_q;
    logic [LEN_W-1:0]  len_q;
    logic [IDX_W-1:0]  idx_q   [2];
    logic [IDX_W-1:0]  idx_calc[2];
    logic              slot_sel_q;
    logic [SLOT_W-1:0] word_q;
    logic              ctr_sel_q;
    logic [WORD_W-1:0] action_q;

    logic              accept;
    logic              word_match;
    logic              last_word;
    logic [PAD_W-1:0]  hdr_padded;
    logic [WORD_W-1:0] hdr_word;
    logic [IDX_W-1:0]  slot_idx;
    logic [SLOT_W-1:0] cnt_ofs;
    logic [WORD_W-1:0] cnt_inc;

    logic              fsm_en, fsm_we;
    logic [ADDR_W-1:0] fsm_addr;
    logic [WORD_W-1:0] fsm_wdata;
    logic              mem_en, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [WORD_W-1:0] mem_wdata;
    logic [WORD_W-1:0] mem_rdata;

    // two index generators, one per polynomial
    for (genvar h = 0; h < 2; h++) begin : g_hash
        flow_crc_index #(
            .HDR_W (HDR_W),
            .PAD_W (PAD_W),
            .IDX_W (IDX_W),
            .POLY  ((h == 0) ? CRC_POLY_IDX0 : CRC_POLY_IDX1),
            .SEED  (CRC_SEED)
        ) u_idx (
            .hdr (hdr_q),
            .idx (idx_calc[h])
        );
    end

    flow_table_mem #(
        .DEPTH (DEPTH),
        .WIDTH (WORD_W)
    ) u_mem (
        .clk   (clk),
        .en    (mem_en),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );

    assign accept     = req_valid && req_ready;
    assign hdr_padded = {{(PAD_W-HDR_W){1'b0}}, hdr_q};
    assign hdr_word   = hdr_padded[PAD_W - 1 - int'(word_q) * WORD_W -: WORD_W];
    assign word_match = (mem_rdata == hdr_word);
    assign last_word  = (word_q == SLOT_W'(HDR_WORDS - 1));
    assign slot_idx   = slot_sel_q ? idx_q[1] : idx_q[0];
    assign cnt_ofs    = SLOT_W'(CNT_OFS) + SLOT_W'({port_q, 1'b0}) + SLOT_W'(ctr_sel_q);
    assign cnt_inc    = ctr_sel_q ? WORD_W'(len_q) : WORD_W'(1);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (accept) state_d = ST_HASH;
            ST_HASH:    state_d = ST_HDR_RD;
            ST_HDR_RD:  state_d = ST_HDR_CMP;
            ST_HDR_CMP: begin
                if (word_match) begin
                    state_d = last_word ? ST_ACT_RD : ST_HDR_RD;
                end else begin
                    state_d = slot_sel_q ? ST_MISS : ST_HDR_RD;
                end
            end
            ST_ACT_RD:  state_d = ST_ACT_CAP;
            ST_ACT_CAP: state_d = ST_CNT_RD;
            ST_CNT_RD:  state_d = ST_CNT_WR;
            ST_CNT_WR:  state_d = ctr_sel_q ? ST_HIT : ST_CNT_RD;
            ST_HIT:     state_d = ST_IDLE;
            ST_MISS:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // datapath registers advanced by the state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_q      <= '0;
            port_q     <= '0;
            len_q      <= '0;
            idx_q[0]   <= '0;
            idx_q[1]   <= '0;
            slot_sel_q <= 1'b0;
            word_q     <= '0;
            ctr_sel_q  <= 1'b0;
            action_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        hdr_q  <= req_hdr;
                        port_q <= req_port;
                        len_q  <= req_len;
                    end
                end
                ST_HASH: begin
                    idx_q[0]   <= idx_calc[0];
                    idx_q[1]   <= idx_calc[1];
                    slot_sel_q <= 1'b0;
                    word_q     <= '0;
                end
                ST_HDR_CMP: begin
                    if (word_match) begin
                        word_q <= word_q + 1'b1;
                    end else begin
                        slot_sel_q <= 1'b1;
                        word_q     <= '0;
                    end
                end
                ST_ACT_CAP: begin
                    action_q  <= mem_rdata;
                    ctr_sel_q <= 1'b0;
                end
                ST_CNT_WR: ctr_sel_q <= 1'b1;
                default: ;
            endcase
        end
    end

    // outputs and memory control decoded from the state
    always_comb begin
        fsm_en     = 1'b0;
        fsm_we     = 1'b0;
        fsm_addr   = '0;
        fsm_wdata  = '0;
        req_ready  = 1'b0;
        res_valid  = 1'b0;
        res_hit    = 1'b0;
        res_drop   = 1'b0;
        res_action = '0;
        unique case (state_q)
            ST_IDLE:   req_ready = !tbl_en;
            ST_HDR_RD: begin
                fsm_en   = 1'b1;
                fsm_addr = {slot_idx, word_q};
            end
            ST_ACT_RD: begin
                fsm_en   = 1'b1;
                fsm_addr = {slot_idx, SLOT_W'(ACT_OFS)};
            end
            ST_CNT_RD: begin
                fsm_en   = 1'b1;
                fsm_addr = {slot_idx, cnt_ofs};
            end
            ST_CNT_WR: begin
                fsm_en    = 1'b1;
                fsm_we    = 1'b1;
                fsm_addr  = {slot_idx, cnt_ofs};
                fsm_wdata = mem_rdata + cnt_inc;
            end
            ST_HIT: begin
                res_valid  = 1'b1;
                res_hit    = 1'b1;
                res_action = action_q;
            end
            ST_MISS: begin
                res_valid = 1'b1;
                res_drop  = 1'b1;
            end
            default: ;
        endcase
    end

    // the host owns the single memory port only while idle
    assign mem_en    = (state_q == ST_IDLE) ? tbl_en    : fsm_en;
    assign mem_we    = (state_q == ST_IDLE) ? tbl_we    : fsm_we;
    assign mem_addr  = (state_q == ST_IDLE) ? tbl_addr  : fsm_addr;
    assign mem_wdata = (state_q == ST_IDLE) ? tbl_wdata : fsm_wdata;
    assign tbl_rdata = mem_rdata;

endmodule

// File: rtl/flow_match_checks.sv
`timescale 1ns/1ps
module flow_match_checks #(
    parameter int WORD_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              res_valid,
    input logic              res_hit,
    input logic              res_drop,
    input logic [WORD_W-1:0] res_action,
    input logic              tbl_en
);

    // R3 R4 R5: a result is either a hit or a drop, never both
    p_hit_xor_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_hit != res_drop));

    // R5: a drop carries no action
    p_drop_no_action_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_drop) |-> (res_action == '0));

    // R7: hit and drop flags only inside the result pulse
    p_flags_in_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (!res_hit && !res_drop));

    // R7: the result lasts exactly one cycle
    p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // R7: busy right after accepting
    p_busy_after_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R7: idle again after the result
    p_ready_after_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> (req_ready || tbl_en));

    // R8: host access blocks acceptance
    p_host_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_en |-> !req_ready);

endmodule

bind flow_match_engine flow_match_checks #(.WORD_W(WORD_W)) u_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .res_valid  (res_valid),
    .res_hit    (res_hit),
    .res_drop   (res_drop),
    .res_action (res_action),
    .tbl_en     (tbl_en)
);

// File: tb/flow_match_engine_test.sv
`timescale 1ns/1ps
module flow_match_engine_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [247:0] req_hdr = '0;
    logic [1:0]   req_port = '0;
    logic [15:0]  req_len = '0;
    logic         res_valid, res_hit, res_drop;
    logic [63:0]  res_action;
    logic         tbl_en = 1'b0;
    logic         tbl_we = 1'b0;
    logic [8:0]   tbl_addr = '0;
    logic [63:0]  tbl_wdata = '0;
    logic [63:0]  tbl_rdata;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    flow_match_engine uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_hdr(req_hdr), .req_port(req_port), .req_len(req_len),
        .res_valid(res_valid), .res_hit(res_hit), .res_drop(res_drop),
        .res_action(res_action),
        .tbl_en(tbl_en), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
        .tbl_wdata(tbl_wdata), .tbl_rdata(tbl_rdata)
    );

    // vector: {flow id (0,1 stored, 2 absent), port, length, expect hit}
    localparam logic [20:0] VEC [8] = '{
        {2'd0, 2'd0, 16'd64,   1'b1},
        {2'd0, 2'd0, 16'd100,  1'b1},
        {2'd0, 2'd3, 16'd1500, 1'b1},
        {2'd1, 2'd1, 16'd60,   1'b1},
        {2'd2, 2'd2, 16'd77,   1'b0},
        {2'd1, 2'd1, 16'd9000, 1'b1},
        {2'd1, 2'd2, 16'd128,  1'b1},
        {2'd2, 2'd0, 16'd40,   1'b0}
    };

    logic [247:0] hdrs  [3];
    logic [63:0]  acts  [2];
    logic [4:0]   slots [2];
    logic [63:0]  m_pkt [2][4];
    logic [63:0]  m_byt [2][4];

    function automatic logic [4:0] ref_idx(input logic [247:0] h, input logic [31:0] poly);
        logic [255:0] p;
        logic [31:0]  c;
        p = {8'd0, h};
        c = 32'hFFFFFFFF;
        for (int i = 0; i < 256; i++) begin
            c = (c[31] ^ p[i]) ? ({c[30:0], 1'b0} ^ poly) : {c[30:0], 1'b0};
        end
        return c[4:0];
    endfunction

    function automatic logic [247:0] mk_hdr(input int s);
        logic [255:0] w;
        for (int k = 0; k < 8; k++) begin
            w[k*32 +: 32] = 32'(s) * 32'h9E3779B9 + 32'(k) * 32'h85EBCA6B + 32'h1234567;
        end
        return w[247:0];
    endfunction

    task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic host_wr(input logic [8:0] a, input logic [63:0] d);
        @(negedge clk);
        tbl_en = 1'b1; tbl_we = 1'b1; tbl_addr = a; tbl_wdata = d;
        @(negedge clk);
        tbl_en = 1'b0; tbl_we = 1'b0;
    endtask

    task automatic host_rd(input logic [8:0] a, output logic [63:0] d);
        @(negedge clk);
        tbl_en = 1'b1; tbl_we = 1'b0; tbl_addr = a;
        @(negedge clk);
        tbl_en = 1'b0;
        d = tbl_rdata;
    endtask

    task automatic lookup(input logic [247:0] h, input logic [1:0] p, input logic [15:0] l,
                          output logic hit, output logic drop, output logic [63:0] act);
        int n;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_hdr = h; req_port = p; req_len = l;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R7 busy after accept", 64'(req_ready), 64'd0);
        n = 0;
        while (!res_valid && n < 200) begin
            @(negedge clk);
            n++;
        end
        chk(res_valid == 1'b1, "R7 result issued", 64'(res_valid), 64'd1);
        hit = res_hit; drop = res_drop; act = res_action;
        @(negedge clk);
        chk(res_valid == 1'b0, "R7 one-cycle result", 64'(res_valid), 64'd0);
    endtask

    task automatic load_flow(input int f, input logic [4:0] s);
        logic [255:0] pw;
        pw = {8'd0, hdrs[f]};
        for (int w = 0; w < 4; w++) host_wr({s, 4'(w)}, pw[255 - w*64 -: 64]);
        host_wr({s, 4'd4}, acts[f]);
        for (int w = 5; w < 13; w++) host_wr({s, 4'(w)}, 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic        hit, drop;
        logic [63:0] act, rd;

        hdrs[0] = mk_hdr(1);
        hdrs[2] = mk_hdr(7777);
        for (int s = 2; s < 1000; s++) begin
            hdrs[1] = mk_hdr(s);
            if (ref_idx(hdrs[1], 32'h04C11DB7) != ref_idx(hdrs[1], 32'h1EDC6F41) &&
                ref_idx(hdrs[1], 32'h1EDC6F41) != ref_idx(hdrs[0], 32'h04C11DB7)) break;
        end
        slots[0] = ref_idx(hdrs[0], 32'h04C11DB7);
        slots[1] = ref_idx(hdrs[1], 32'h1EDC6F41);
        acts[0] = 64'hA0A0_0000_0000_0011;
        acts[1] = 64'hB1B1_0000_0000_0022;
        for (int f = 0; f < 2; f++)
            for (int p = 0; p < 4; p++) begin
                m_pkt[f][p] = '0;
                m_byt[f][p] = '0;
            end

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(res_valid == 1'b0, "R9 reset res_valid", 64'(res_valid), 64'd0);
        chk(req_ready == 1'b1, "R9 reset req_ready", 64'(req_ready), 64'd1);

        load_flow(0, slots[0]);   // index-0 slot only
        load_flow(1, slots[1]);   // index-1 slot only

        // R8 R2: host readback of header word 0 and blocking of acceptance
        @(negedge clk);
        tbl_en = 1'b1; tbl_we = 1'b0; tbl_addr = {slots[0], 4'd0};
        #1;
        chk(req_ready == 1'b0, "R8 host access blocks ready", 64'(req_ready), 64'd0);
        @(negedge clk);
        tbl_en = 1'b0;
        chk(tbl_rdata == {8'd0, hdrs[0][247:192]}, "R8 R2 header word 0 readback",
            tbl_rdata, {8'd0, hdrs[0][247:192]});

        foreach (VEC[i]) begin
            int          f;
            logic [1:0]  p;
            logic [15:0] l;
            logic        eh;
            f  = int'(VEC[i][20:19]);
            p  = VEC[i][18:17];
            l  = VEC[i][16:1];
            eh = VEC[i][0];
            lookup(hdrs[f], p, l, hit, drop, act);
            if (eh) begin
                chk(hit == 1'b1 && drop == 1'b0,
                    (f == 0) ? "R1 R3 index-0 hit" : "R1 R4 index-1 hit",
                    {62'd0, hit, drop}, 64'd2);
                chk(act == acts[f], "R3 R4 action word", act, acts[f]);
                m_pkt[f][p] += 64'd1;
                m_byt[f][p] += 64'(l);
            end else begin
                chk(hit == 1'b0 && drop == 1'b1, "R5 miss drops", {62'd0, hit, drop}, 64'd1);
                chk(act == 64'd0, "R5 miss action zero", act, 64'd0);
            end
        end

        // R6 R5: every port's counters in both slots
        for (int f = 0; f < 2; f++)
            for (int p = 0; p < 4; p++) begin
                host_rd({slots[f], 4'(5 + 2*p)}, rd);
                chk(rd == m_pkt[f][p], "R6 packet counter", rd, m_pkt[f][p]);
                host_rd({slots[f], 4'(6 + 2*p)}, rd);
                chk(rd == m_byt[f][p], "R6 byte counter", rd, m_byt[f][p]);
            end

        // R4: removing flow 1 from its slot turns it into a miss
        host_wr({slots[1], 4'd3}, 64'h0);
        lookup(hdrs[1], 2'd0, 16'd10, hit, drop, act);
        chk(drop == 1'b1 && hit == 1'b0, "R5 cleared slot drops", {62'd0, hit, drop}, 64'd1);
        host_rd({slots[1], 4'd5}, rd);
        chk(rd == m_pkt[1][0], "R5 counter untouched on miss", rd, m_pkt[1][0]);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule